// File: doc/BRIEF.md
# Configuration Boot-Memory Loader

When the bus reset is released, this block fills a 64-byte configuration image from an external byte-wide non-volatile memory. It drives a 16-bit address and samples an 8-bit data bus. Each access takes a fixed number of clock cycles. The block first checks two vendor-identity bytes to see whether the memory is blank. It then checks a four-byte signature. Only when both checks pass does it copy the 64-byte setup region into the image. In every other case the hard-wired default image is kept.

Host configuration reads use a valid/ready port. The block holds `host_cfg_ready` low, which inserts wait states, until the loader has reached its decision and finished any copy. After that, `host_cfg_ready` stays high until the next bus reset. Because ready does not depend on valid, the host may keep valid asserted throughout the stall. A read completes in the cycle in which valid and ready are both high, and its data is returned combinationally in that cycle.

The add-on reset output is a direct copy of the bus reset. A status output tells whether the image came from the memory or from the defaults. A mode input selects the boot device. When this input is high, the parallel loader stays idle and the defaults are used.

Top module: `cfg_boot_loader`

## Requirements
- R1: `addon_rst_n` equals `bus_rst_n` at all times. It follows the bus reset in the same delta cycle, with no clock edge in between.
- R2: While `bus_rst_n` is low, every image byte at offset i holds its default 0xA0 XOR i, `nv_addr` is 0x0040, and `host_cfg_ready` and `boot_from_nv` are low. A reset during a copy restores these defaults.
- R3: Each memory address is held for exactly 8 clock cycles. The data is sampled at the 8th rising edge, and the next address appears after that edge. The first address, 0x0040, is present from the release of the reset.
- R4: The addresses are read in this order: 0x0040, 0x0041, then 0x0050 to 0x0053, then 0x0040 to 0x007F. Only the steps reached are read. `nv_addr` never leaves the range 0x0040 to 0x007F.
- R5: If the bytes at 0x0040 and 0x0041 are both 0xFF, the defaults are kept and `host_cfg_ready` rises after 16 cycles with `boot_from_nv` low. If only one of these bytes is 0xFF, the signature check goes ahead.
- R6: The signature at 0x0050 to 0x0053 must be {0xC0, 0xC1 or 0xC2}, 0xFF, 0xE8, 0x10. The first mismatching byte ends the check at that access. The defaults are kept, `boot_from_nv` stays low, and ready rises 8 cycles after the last access begins.
- R7: With a valid signature, image offset i receives the byte at 0x0040+i for all 64 offsets. `host_cfg_ready` then rises 560 cycles after the reset release, and `boot_from_nv` is high.
- R8: `host_cfg_ready` stays low until the loader is done. Once high, it stays high until the next reset.
- R9: `host_cfg_rdata` returns image byte `host_cfg_addr` when `host_cfg_valid` and `host_cfg_ready` are both high. Otherwise it is 0x00.
- R10: With `par_boot_n` high, no address other than 0x0040 is driven, the defaults are kept, and ready rises one cycle after the reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Bus reset, active low, asynchronous |
| par_boot_n | input | 1 | Low selects the byte-wide memory loader |
| nv_addr | output | 16 | Memory address bus |
| nv_data | input | 8 | Memory data bus |
| addon_rst_n | output | 1 | Add-on reset, follows bus_rst_n |
| host_cfg_valid | input | 1 | Host configuration read request |
| host_cfg_addr | input | 6 | Image byte offset to read |
| host_cfg_ready | output | 1 | Configuration ready; low inserts wait states |
| host_cfg_rdata | output | 8 | Read data, valid on a transfer |
| boot_from_nv | output | 1 | High when the image was loaded from memory |

## Verification
The hardest situations to reach are a signature that fails only at its second, third or fourth byte, and a bus reset that arrives while the copy is under way. The stimulus writes memory images that match the signature up to a chosen position and then corrupt one byte. A bench model derives the expected address schedule, cycle count and image from the memory contents alone. For the mid-copy case, the bench releases reset on a valid memory, asserts reset again after several bytes have been written, and then boots from a blank memory. Every image byte must read back as its default.

// File: rtl/cfg_boot_pkg.sv
package cfg_boot_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_VID  = 2'd0,
    ST_SIG  = 2'd1,
    ST_LOAD = 2'd2,
    ST_DONE = 2'd3
  } boot_st_e;

  function automatic logic [BYTE_W-1:0] dflt_byte(input int unsigned ofs);
    return 8'hA0 ^ 8'(ofs);
  endfunction

  function automatic logic sig_match(input logic [1:0] pos, input logic [BYTE_W-1:0] b);
    case (pos)
      2'd0:    return (b == 8'hC0) || (b == 8'hC1) || (b == 8'hC2);
      2'd1:    return b == 8'hFF;
      2'd2:    return b == 8'hE8;
      default: return b == 8'h10;
    endcase
  endfunction
endpackage

// File: rtl/nv_access_timer.sv
module nv_access_timer #(
  parameter int unsigned ACC_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (ACC_CYCLES > 1) ? $clog2(ACC_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ACC_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (en_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);

  // R3: one sample per access, never two edges in a row
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/cfg_image.sv
module cfg_image
  import cfg_boot_pkg::*;
#(
  parameter int unsigned N_BYTES = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we_i,
  input  logic [$clog2(N_BYTES)-1:0] waddr_i,
  input  logic [BYTE_W-1:0]         wdata_i,
  input  logic [$clog2(N_BYTES)-1:0] raddr_i,
  output logic [BYTE_W-1:0]         rdata_o
);
  localparam int unsigned IDX_W = $clog2(N_BYTES);

  logic [BYTE_W-1:0] img_q [N_BYTES];

  for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                img_q[g] <= dflt_byte(g);
      else if (we_i && (waddr_i == IDX_W'(g)))   img_q[g] <= wdata_i;
    end
  end

  assign rdata_o = img_q[raddr_i];

  // R7: a write lands in the addressed byte
  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (img_q[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/cfg_boot_seq.sv
module cfg_boot_seq
  import cfg_boot_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned IMG_BYTES = 64,
  parameter int unsigned SIG_LEN   = 4,
  parameter logic [15:0] LOAD_BASE = 16'h0040,
  parameter logic [15:0] SIG_BASE  = 16'h0050
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         par_sel_n_i,
  input  logic                         tick_i,
  input  logic [BYTE_W-1:0]            data_i,
  output logic                         run_o,
  output logic [ADDR_W-1:0]            addr_o,
  output logic                         we_o,
  output logic [$clog2(IMG_BYTES)-1:0] waddr_o,
  output logic [BYTE_W-1:0]            wdata_o,
  output logic                         done_o,
  output logic                         from_nv_o
);
  localparam int unsigned IDX_W = $clog2(IMG_BYTES);
  localparam logic [IDX_W-1:0] SIG_LAST = IDX_W'(SIG_LEN - 1);
  localparam logic [IDX_W-1:0] IMG_LAST = IDX_W'(IMG_BYTES - 1);
  localparam logic [BYTE_W-1:0] BLANK   = '1;

  boot_st_e         st_q;
  logic [IDX_W-1:0] ofs_q;
  logic             vid_blank_q;
  logic             from_nv_q;
  logic [ADDR_W-1:0] base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_VID;
      ofs_q       <= '0;
      vid_blank_q <= 1'b0;
      from_nv_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_VID: begin
          if (par_sel_n_i) begin
            st_q <= ST_DONE;
          end else if (tick_i) begin
            if (ofs_q == '0) begin
              vid_blank_q <= (data_i == BLANK);
              ofs_q       <= ofs_q + 1'b1;
            end else begin
              st_q  <= (vid_blank_q && (data_i == BLANK)) ? ST_DONE : ST_SIG;
              ofs_q <= '0;
            end
          end
        end
        ST_SIG: begin
          if (tick_i) begin
            if (!sig_match(ofs_q[1:0], data_i)) begin
              st_q  <= ST_DONE;
              ofs_q <= '0;
            end else if (ofs_q == SIG_LAST) begin
              st_q  <= ST_LOAD;
              ofs_q <= '0;
            end else begin
              ofs_q <= ofs_q + 1'b1;
            end
          end
        end
        ST_LOAD: begin
          if (tick_i) begin
            if (ofs_q == IMG_LAST) begin
              st_q      <= ST_DONE;
              from_nv_q <= 1'b1;
              ofs_q     <= '0;
            end else begin
              ofs_q <= ofs_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign base      = (st_q == ST_SIG) ? ADDR_W'(SIG_BASE) : ADDR_W'(LOAD_BASE);
  assign addr_o    = base + ADDR_W'(ofs_q);
  assign run_o     = (st_q != ST_DONE) && !par_sel_n_i;
  assign we_o      = tick_i && (st_q == ST_LOAD);
  assign waddr_o   = ofs_q;
  assign wdata_o   = data_i;
  assign done_o    = (st_q == ST_DONE);
  assign from_nv_o = from_nv_q;

  // R3: the address only moves on the edge that samples data
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick_i) |-> $stable(addr_o));
  // R4: address stays inside the boot window
  a_r4_addr_window: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_o >= ADDR_W'(LOAD_BASE)) && (addr_o < ADDR_W'(LOAD_BASE) + ADDR_W'(IMG_BYTES)));
  // R8: once ready, stays ready
  a_r8_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);
  // R7: memory status only once the loader is finished
  a_r7_nv_flag_done: assert property (@(posedge clk) disable iff (!rst_n)
    from_nv_o |-> done_o);
endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader
  import cfg_boot_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned IMG_BYTES  = 64,
  parameter int unsigned ACC_CYCLES = 8,
  parameter logic [15:0] LOAD_BASE  = 16'h0040,
  parameter logic [15:0] SIG_BASE   = 16'h0050
) (
  input  logic                         clk,
  input  logic                         bus_rst_n,
  input  logic                         par_boot_n,
  output logic [ADDR_W-1:0]            nv_addr,
  input  logic [BYTE_W-1:0]            nv_data,
  output logic                         addon_rst_n,
  input  logic                         host_cfg_valid,
  input  logic [$clog2(IMG_BYTES)-1:0] host_cfg_addr,
  output logic                         host_cfg_ready,
  output logic [BYTE_W-1:0]            host_cfg_rdata,
  output logic                         boot_from_nv
);
  localparam int unsigned IDX_W = $clog2(IMG_BYTES);

  logic              run, tick, we, done;
  logic [IDX_W-1:0]  waddr;
  logic [BYTE_W-1:0] wdata, img_rd;

  assign addon_rst_n = bus_rst_n;

  nv_access_timer #(.ACC_CYCLES(ACC_CYCLES)) u_timer (
    .clk(clk), .rst_n(bus_rst_n), .en_i(run), .tick_o(tick)
  );

  cfg_boot_seq #(
    .ADDR_W(ADDR_W), .IMG_BYTES(IMG_BYTES), .SIG_LEN(4),
    .LOAD_BASE(LOAD_BASE), .SIG_BASE(SIG_BASE)
  ) u_seq (
    .clk(clk), .rst_n(bus_rst_n), .par_sel_n_i(par_boot_n),
    .tick_i(tick), .data_i(nv_data), .run_o(run), .addr_o(nv_addr),
    .we_o(we), .waddr_o(waddr), .wdata_o(wdata),
    .done_o(done), .from_nv_o(boot_from_nv)
  );

  cfg_image #(.N_BYTES(IMG_BYTES)) u_image (
    .clk(clk), .rst_n(bus_rst_n), .we_i(we), .waddr_i(waddr),
    .wdata_i(wdata), .raddr_i(host_cfg_addr), .rdata_o(img_rd)
  );

  assign host_cfg_ready = done;
  assign host_cfg_rdata = (host_cfg_valid && done) ? img_rd : '0;

  // R8: no image write once host accesses are acknowledged
  a_r8_no_write_when_ready: assert property (@(posedge clk) disable iff (!bus_rst_n)
    we |-> !host_cfg_ready);
endmodule

// File: tb/test_cfg_boot_loader.sv
`timescale 1ns/1ps
module test_cfg_boot_loader;
  logic        clk = 1'b0;
  logic        bus_rst_n = 1'b0;
  logic        par_boot_n = 1'b0;
  logic [15:0] nv_addr;
  logic [7:0]  nv_data;
  logic        addon_rst_n;
  logic        host_cfg_valid = 1'b0;
  logic [5:0]  host_cfg_addr = '0;
  logic        host_cfg_ready;
  logic [7:0]  host_cfg_rdata;
  logic        boot_from_nv;

  always #2.5 clk = ~clk;

  logic [7:0] nvm [128];
  assign nv_data = (nv_addr < 16'h0080) ? nvm[nv_addr[6:0]] : 8'hFF;

  cfg_boot_loader i_cfg_boot_loader (
    .clk(clk), .bus_rst_n(bus_rst_n), .par_boot_n(par_boot_n),
    .nv_addr(nv_addr), .nv_data(nv_data), .addon_rst_n(addon_rst_n),
    .host_cfg_valid(host_cfg_valid), .host_cfg_addr(host_cfg_addr),
    .host_cfg_ready(host_cfg_ready), .host_cfg_rdata(host_cfg_rdata),
    .boot_from_nv(boot_from_nv)
  );

  int n_chk = 0;
  int n_fail = 0;
  int exp_seq [80];
  int exp_len;
  int exp_cyc;
  bit exp_nv;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit sig_ok_tb(input int k, input logic [7:0] b);
    case (k)
      0: return (b == 8'hC0) || (b == 8'hC1) || (b == 8'hC2);
      1: return b == 8'hFF;
      2: return b == 8'hE8;
      default: return b == 8'h10;
    endcase
  endfunction

  function automatic logic [7:0] dflt_tb(input int i);
    return 8'hA0 ^ 8'(i);
  endfunction

  task automatic fill_random();
    for (int i = 0; i < 128; i++) nvm[i] = 8'($urandom);
  endtask

  task automatic make_valid(input logic [7:0] s0);
    fill_random();
    if (nvm[8'h40] == 8'hFF && nvm[8'h41] == 8'hFF) nvm[8'h41] = 8'h00;
    nvm[8'h50] = s0; nvm[8'h51] = 8'hFF; nvm[8'h52] = 8'hE8; nvm[8'h53] = 8'h10;
  endtask

  task automatic make_blank();
    fill_random();
    nvm[8'h40] = 8'hFF; nvm[8'h41] = 8'hFF;
  endtask

  task automatic make_badsig(input int k);
    make_valid(8'hC0);
    if (k == 0) nvm[8'h50] = 8'hC3;
    else        nvm[8'h50 + k] = ~nvm[8'h50 + k];
  endtask

  // bench model: expected schedule derived from memory contents (R4..R7, R10)
  task automatic predict(input bit mode_hi);
    exp_len = 0; exp_nv = 1'b0;
    if (mode_hi) begin
      exp_seq[0] = 'h40; exp_len = 1; exp_cyc = 1;
      return;
    end
    exp_seq[exp_len++] = 'h40;
    exp_seq[exp_len++] = 'h41;
    if (!(nvm[8'h40] == 8'hFF && nvm[8'h41] == 8'hFF)) begin
      bit good = 1'b1;
      for (int k = 0; k < 4 && good; k++) begin
        exp_seq[exp_len++] = 'h50 + k;
        good = sig_ok_tb(k, nvm[8'h50 + k]);
      end
      if (good) begin
        for (int i = 0; i < 64; i++) exp_seq[exp_len++] = 'h40 + i;
        exp_nv = 1'b1;
      end
    end
    exp_cyc = 8 * exp_len;
  endtask

  task automatic boot(input string tag, input bit mode_hi);
    int cyc = 0;
    int addr_bad = 0;
    int rdata_bad = 0;
    predict(mode_hi);
    @(negedge clk);
    bus_rst_n = 1'b0; par_boot_n = mode_hi; host_cfg_valid = 1'b0;
    #1 check(addon_rst_n == 1'b0, "R1", "addon reset follows assert", addon_rst_n, 0);
    repeat (2) @(negedge clk);
    check(nv_addr == 16'h0040, "R2", "reset address", nv_addr, 'h40);
    check(host_cfg_ready == 1'b0 && boot_from_nv == 1'b0, "R2", "reset ready/status",
          {host_cfg_ready, boot_from_nv}, 0);
    bus_rst_n = 1'b1;
    #1 check(addon_rst_n == 1'b1, "R1", "addon reset follows release", addon_rst_n, 1);
    host_cfg_valid = 1'b1;
    host_cfg_addr  = 6'($urandom);
    while (!host_cfg_ready && cyc < 1000) begin
      if (cyc / 8 < exp_len && int'(nv_addr) != exp_seq[cyc / 8]) addr_bad++;
      if (host_cfg_rdata != 8'h00) rdata_bad++;
      @(negedge clk);
      cyc++;
    end
    check(addr_bad == 0, "R3,R4", "address schedule mismatches", addr_bad, 0);
    check(cyc == exp_cyc, tag, "cycles until ready", cyc, exp_cyc);
    check(boot_from_nv == exp_nv, tag, "load source status", boot_from_nv, exp_nv);
    check(rdata_bad == 0, "R9", "rdata nonzero during wait states", rdata_bad, 0);
    for (int i = 0; i < 64; i++) begin
      logic [7:0] e;
      host_cfg_addr = 6'(i);
      #1;
      e = exp_nv ? nvm[64 + i] : dflt_tb(i);
      check(host_cfg_rdata == e, tag, "image byte", host_cfg_rdata, e);
    end
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      host_cfg_valid = 1'($urandom);
      #1;
      check(host_cfg_ready == 1'b1, "R8", "ready held after done", host_cfg_ready, 1);
      if (!host_cfg_valid)
        check(host_cfg_rdata == 8'h00, "R9", "rdata idle without valid", host_cfg_rdata, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 128; i++) nvm[i] = 8'hFF;

    make_blank();          boot("R5", 1'b0);
    make_valid(8'hC0);     nvm[8'h40] = 8'hFF; nvm[8'h41] = 8'h12;
                           boot("R5", 1'b0);   // only one identity byte blank
    make_valid(8'hC0);     boot("R7", 1'b0);
    make_valid(8'hC1);     boot("R6", 1'b0);
    make_valid(8'hC2);     boot("R6", 1'b0);
    for (int k = 0; k < 4; k++) begin
      make_badsig(k);      boot("R6", 1'b0);
    end
    make_valid(8'hC1);     boot("R10", 1'b1);

    // R2: reset in the middle of a copy, then a blank boot must show defaults
    make_valid(8'hC1);
    @(negedge clk); bus_rst_n = 1'b0; par_boot_n = 1'b0;
    repeat (2) @(negedge clk);
    bus_rst_n = 1'b1;
    repeat (120) @(negedge clk);
    check(host_cfg_ready == 1'b0, "R8", "stalled during copy", host_cfg_ready, 0);
    bus_rst_n = 1'b0;
    #1 check(addon_rst_n == 1'b0, "R1", "addon reset mid copy", addon_rst_n, 0);
    make_blank();          boot("R2", 1'b0);

    for (int r = 0; r < 4; r++) begin
      int kind = int'($urandom_range(0, 2));
      if (kind == 0)      begin make_blank();                           boot("R5", 1'b0); end
      else if (kind == 1) begin make_valid(8'hC0 + 8'($urandom_range(0, 2))); boot("R7", 1'b0); end
      else                begin make_badsig(int'($urandom_range(0, 3)));     boot("R6", 1'b0); end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule